// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block is the front end of a small 4-bit microcontroller core whose program store holds 10-bit instruction words. It owns a 14-bit program counter and drives it onto the program memory address, one word per cycle. From each first word it decides whether the instruction also carries an operand word. It hands the execute stage a registered instruction record: opcode, operand, length, and the address that follows the instruction. Alongside the record it gives a decoded control-transfer target.

The execute stage steers the sequencer through two inputs. A redirect loads a new program counter after a taken branch, call or return, and throws away a half-fetched instruction. A stall freezes fetch without losing a pending operand word. Targets come in three forms. A short branch stays inside the current 256-word page. A short call jumps to one of 64 fixed low vectors. A long jump, call or branch builds a full 14-bit address from the opcode's low nibble and the operand word.

The program memory read is assumed to return, within the same cycle, the word addressed by the sequencer's registered address output. The sequencer's own output registers are the only fetch pipeline stage.

Top module: `fetch_seq`

## Requirements
- R1: Only `rom_data[9:0]` is decoded; bits 15:10 of `rom_data` never change any output.
- R2: `rom_addr` is the 14-bit program counter. Each accepted fetch cycle (no stall, no redirect) increments it by one, and 0x3FFF wraps to 0x0000.
- R3: Opcodes 0x100–0x13F and 0x150–0x1AF are two-word instructions. After the opcode, the following word is fetched as the operand. One `instr_valid` pulse then carries `instr_len`=2, `instr_op`=opcode and `instr_arg`=operand. Any other opcode gives `instr_len`=1 and `instr_arg`=0. `instr_valid` rises on the clock edge that fetches the instruction's last word. `instr_next_pc` is the address after that word.
- R4: Opcodes 0x300–0x3FF give `tgt_kind`=1 (short branch). The target is bits 13:8 of `instr_next_pc` joined with opcode bits 7:0, so the page wraps at the top of the address space.
- R5: Opcodes 0x1C0–0x1FF give `tgt_kind`=2 (short call). The target is opcode bits 5:0, zero-extended, so it lies in 0..63.
- R6: Opcodes 0x150–0x15F, 0x160–0x16F and 0x170–0x17F give `tgt_kind` 3 (long jump), 4 (long call) and 5 (long branch). The target is opcode bits 3:0 as address bits 13:10 and the operand as bits 9:0.
- R7: Every other opcode gives `tgt_kind`=0. `tgt_kind` is also 0 whenever `instr_valid` is low.
- R8: With `redir_valid` high at a clock edge, `rom_addr` becomes `redir_addr` and any pending operand fetch is dropped. `instr_valid` is low in the following cycle. Redirect takes priority over stall.
- R9: With `stall` high and no redirect, the program counter, the pending-operand state and the held opcode keep their values, and `instr_valid` is low in the following cycle. A pending operand is fetched once the stall is released.
- R10: Synchronous active-low reset sets `rom_addr` to 0x0000, clears the pending-operand state and holds `instr_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Freeze fetch for this cycle |
| redir_valid | input | 1 | Load `redir_addr` into the program counter |
| redir_addr | input | 14 | New program counter value |
| rom_addr | output | 14 | Program memory address (program counter) |
| rom_data | input | 16 | Program memory word; low 10 bits used |
| instr_valid | output | 1 | Instruction record valid this cycle |
| instr_op | output | 10 | Opcode word |
| instr_arg | output | 10 | Operand word, 0 for single-word instructions |
| instr_len | output | 2 | Instruction length in words (1 or 2) |
| instr_next_pc | output | 14 | Address following the instruction |
| tgt_kind | output | 3 | 0 none, 1 short branch, 2 short call, 3 long jump, 4 long call, 5 long branch |
| tgt_addr | output | 14 | Control-transfer target address |

## Verification
The collision that matters most is a redirect or a stall arriving in the same cycle as the fetch of a pending operand word. The redirect must discard the held opcode. The stall must keep it and resume with the correct operand. The bench provokes both with directed sequences: it loads a two-word opcode and then redirects, stalls, or does both at once. It then runs a long phase with random stalls and redirects. A behavioural model, stepped on every edge, predicts every output, and each cycle is compared against it. A full sweep redirects once to each of the 1024 opcode values across varying pages, and patched words at 0x3FFF test page and address wrap.

// File: rtl/fseq_pkg.sv
// Package: shared types and constants of the fetch sequencer.
// Assumes 10-bit instruction words; operand-bearing opcode ranges are
// listed as inclusive low/high pairs.
package fseq_pkg;

    typedef enum logic [2:0] {
        TK_NONE  = 3'd0,
        TK_SBR   = 3'd1,
        TK_SCALL = 3'd2,
        TK_LJMP  = 3'd3,
        TK_LCALL = 3'd4,
        TK_LBR   = 3'd5
    } tgt_kind_e;

    localparam int OPND_RANGES = 2;
    // index 0: 0x100..0x13F, index 1: 0x150..0x1AF
    localparam logic [OPND_RANGES-1:0][9:0] OPND_LO = {10'h150, 10'h100};
    localparam logic [OPND_RANGES-1:0][9:0] OPND_HI = {10'h1AF, 10'h13F};

endpackage

// File: rtl/fseq_len_dec.sv
// Module: length decoder. Flags a word whose value lies in one of the
// operand-bearing opcode ranges of fseq_pkg. Purely combinational.
// Assumes WORD_W is wide enough to hold the range bounds.
module fseq_len_dec
    import fseq_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic [WORD_W-1:0] word,
    output logic              two_word
);

    logic [OPND_RANGES-1:0] hit;

    // one comparator pair per opcode range
    for (genvar g = 0; g < OPND_RANGES; g++) begin : g_rng
        assign hit[g] = (word >= WORD_W'(OPND_LO[g])) &&
                        (word <= WORD_W'(OPND_HI[g]));
    end

    assign two_word = |hit;

endmodule

// File: rtl/fseq_pc.sv
// Module: program counter register. Loads on redirect, otherwise steps by
// one when advance is high; wraps naturally at 2**PC_W.
// Assumes load and advance are never both meant to step (load wins).
module fseq_pc #(
    parameter int PC_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PC_W-1:0] load_addr,
    input  logic            advance,
    output logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] pc_inc
);

    assign pc_inc = pc + PC_W'(1);

    // counter update: reset, redirect load, or sequential step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (load) begin
            pc <= load_addr;
        end else if (advance) begin
            pc <= pc_inc;
        end
    end

endmodule

// File: rtl/fseq_tgt.sv
// Module: control-transfer target decoder. From the registered instruction
// record it classifies the opcode and forms the target address.
// Assumes WORD_W = 10 opcode encoding and PC_W > WORD_W.
module fseq_tgt
    import fseq_pkg::*;
#(
    parameter int PC_W    = 14,
    parameter int WORD_W  = 10,
    parameter int SBR_W   = 8,
    parameter int SCALL_W = 6
) (
    input  logic              valid,
    input  logic [WORD_W-1:0] op,
    input  logic [WORD_W-1:0] arg,
    input  logic [PC_W-1:0]   next_pc,
    output tgt_kind_e         kind,
    output logic [PC_W-1:0]   addr
);

    localparam int HI_W = PC_W - WORD_W;

    logic [PC_W-1:0] sbr_addr;
    logic [PC_W-1:0] scall_addr;
    logic [PC_W-1:0] long_addr;

    assign sbr_addr   = {next_pc[PC_W-1:SBR_W], op[SBR_W-1:0]};
    assign scall_addr = PC_W'(op[SCALL_W-1:0]);
    assign long_addr  = {op[HI_W-1:0], arg};

    // classification and target selection
    always_comb begin
        kind = TK_NONE;
        addr = '0;
        if (valid) begin
            if (op >= WORD_W'(10'h300)) begin
                kind = TK_SBR;
                addr = sbr_addr;
            end else if (op >= WORD_W'(10'h1C0) && op <= WORD_W'(10'h1FF)) begin
                kind = TK_SCALL;
                addr = scall_addr;
            end else if (op >= WORD_W'(10'h150) && op <= WORD_W'(10'h15F)) begin
                kind = TK_LJMP;
                addr = long_addr;
            end else if (op >= WORD_W'(10'h160) && op <= WORD_W'(10'h16F)) begin
                kind = TK_LCALL;
                addr = long_addr;
            end else if (op >= WORD_W'(10'h170) && op <= WORD_W'(10'h17F)) begin
                kind = TK_LBR;
                addr = long_addr;
            end
        end
    end

endmodule

// File: rtl/fetch_seq.sv
// Module: two-word instruction fetch sequencer (top). Drives the program
// counter to memory, holds a first word that needs an operand, and emits a
// registered instruction record plus decoded target.
// Assumes rom_data returns the word at rom_addr within the same cycle.
module fetch_seq
    import fseq_pkg::*;
#(
    parameter int PC_W   = 14,
    parameter int WORD_W = 10,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              redir_valid,
    input  logic [PC_W-1:0]   redir_addr,
    output logic [PC_W-1:0]   rom_addr,
    input  logic [BUS_W-1:0]  rom_data,
    output logic              instr_valid,
    output logic [WORD_W-1:0] instr_op,
    output logic [WORD_W-1:0] instr_arg,
    output logic [1:0]        instr_len,
    output logic [PC_W-1:0]   instr_next_pc,
    output logic [2:0]        tgt_kind,
    output logic [PC_W-1:0]   tgt_addr
);

    logic [WORD_W-1:0] word;
    logic              two_word;
    logic              advance;
    logic [PC_W-1:0]   pc;
    logic [PC_W-1:0]   pc_inc;
    logic              pending_q;
    logic [WORD_W-1:0] hold_q;
    tgt_kind_e         kind;

    assign word    = rom_data[WORD_W-1:0];
    assign advance = !redir_valid && !stall;

    fseq_len_dec #(.WORD_W(WORD_W)) u_len (
        .word     (word),
        .two_word (two_word)
    );

    fseq_pc #(.PC_W(PC_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (redir_valid),
        .load_addr (redir_addr),
        .advance   (advance),
        .pc        (pc),
        .pc_inc    (pc_inc)
    );

    // instruction assembly: hold opcode, capture operand, emit record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q     <= 1'b0;
            hold_q        <= '0;
            instr_valid   <= 1'b0;
            instr_op      <= '0;
            instr_arg     <= '0;
            instr_len     <= 2'd0;
            instr_next_pc <= '0;
        end else if (redir_valid) begin
            pending_q   <= 1'b0;
            instr_valid <= 1'b0;
        end else if (stall) begin
            instr_valid <= 1'b0;
        end else if (pending_q) begin
            pending_q     <= 1'b0;
            instr_valid   <= 1'b1;
            instr_op      <= hold_q;
            instr_arg     <= word;
            instr_len     <= 2'd2;
            instr_next_pc <= pc_inc;
        end else if (two_word) begin
            pending_q   <= 1'b1;
            hold_q      <= word;
            instr_valid <= 1'b0;
        end else begin
            instr_valid   <= 1'b1;
            instr_op      <= word;
            instr_arg     <= '0;
            instr_len     <= 2'd1;
            instr_next_pc <= pc_inc;
        end
    end

    fseq_tgt #(.PC_W(PC_W), .WORD_W(WORD_W)) u_tgt (
        .valid   (instr_valid),
        .op      (instr_op),
        .arg     (instr_arg),
        .next_pc (instr_next_pc),
        .kind    (kind),
        .addr    (tgt_addr)
    );

    assign rom_addr = pc;
    assign tgt_kind = kind;

    // R2: an accepted fetch steps the counter by exactly one
    a_r2_pc_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !redir_valid) |=> (pc == $past(pc) + PC_W'(1)));

    // R3: a two-word record is only emitted after a pending opcode
    a_r3_len2_after_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_len == 2'd2) |-> $past(pending_q));

    // R5: short call targets stay in the low vector area
    a_r5_call_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_kind == 3'(TK_SCALL)) |-> (tgt_addr < PC_W'(64)));

    // R7: no target kind without a valid record
    a_r7_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> (tgt_kind == 3'(TK_NONE)));

    // R8: redirect loads the counter and blanks the next record
    a_r8_redirect_loads: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> ((pc == $past(redir_addr)) && !instr_valid && !pending_q));

    // R9: stall freezes counter and pending state
    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !redir_valid) |=> ($stable(pc) && $stable(pending_q) && !instr_valid));

endmodule

// File: tb/test_fetch_seq.sv
`timescale 1ns/1ps
module test_fetch_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic        redir_valid = 1'b0;
    logic [13:0] redir_addr = '0;
    logic [13:0] rom_addr;
    logic [15:0] rom_data;
    logic        instr_valid;
    logic [9:0]  instr_op;
    logic [9:0]  instr_arg;
    logic [1:0]  instr_len;
    logic [13:0] instr_next_pc;
    logic [2:0]  tgt_kind;
    logic [13:0] tgt_addr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    string ph = "R10 reset";

    // program store patch for wrap tests
    bit        patch_en = 0;
    int        patch_a = 0;
    int        patch_v = 0;

    always #2.5 clk = ~clk;

    fetch_seq i_fetch_seq (
        .clk, .rst_n, .stall, .redir_valid, .redir_addr, .rom_addr, .rom_data,
        .instr_valid, .instr_op, .instr_arg, .instr_len, .instr_next_pc,
        .tgt_kind, .tgt_addr
    );

    function automatic int page_mask(int a);
        int p = (a >> 10) & 15;
        return (p << 6) | (p << 2) | (p >> 2);
    endfunction

    // program word at address a; upper bus bits are junk (R1)
    function automatic int rom_word(int a);
        if (patch_en && a == patch_a) return (6'h2A << 10) | patch_v;
        return ((~a & 63) << 10) | ((a & 10'h3FF) ^ page_mask(a));
    endfunction

    always_comb begin
        if (patch_en && int'(rom_addr) == patch_a)
            rom_data = {6'h2A, 10'(patch_v)};
        else
            rom_data = {~rom_addr[5:0], rom_addr[9:0] ^ 10'(page_mask(int'(rom_addr)))};
    end

    // behavioural reference model, stepped on every edge
    int m_pc = 0, m_pend = 0, m_hold = 0, m_valid = 0;
    int m_op = 0, m_arg = 0, m_len = 0, m_nxt = 0;

    function automatic bit needs_opnd(int w);
        return (w >= 'h100 && w <= 'h13F) || (w >= 'h150 && w <= 'h1AF);
    endfunction

    always @(posedge clk) begin
        int w;
        if (!rst_n) begin
            m_pc = 0; m_pend = 0; m_valid = 0;
        end else if (redir_valid) begin
            m_pc = int'(redir_addr); m_pend = 0; m_valid = 0;
        end else if (stall) begin
            m_valid = 0;
        end else begin
            w = rom_word(m_pc) & 10'h3FF;
            if (m_pend != 0) begin
                m_valid = 1; m_op = m_hold; m_arg = w; m_len = 2;
                m_nxt = (m_pc + 1) & 14'h3FFF; m_pend = 0;
            end else if (needs_opnd(w)) begin
                m_hold = w; m_pend = 1; m_valid = 0;
            end else begin
                m_valid = 1; m_op = w; m_arg = 0; m_len = 1;
                m_nxt = (m_pc + 1) & 14'h3FFF;
            end
            m_pc = (m_pc + 1) & 14'h3FFF;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, ph, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int k, ta;
        string t;
        chk("R2 R8 R9 R10 rom_addr", int'(rom_addr), m_pc);
        chk("R3 R8 R9 instr_valid", int'(instr_valid), m_valid);
        if (m_valid != 0) begin
            chk("R1 R3 instr_op", int'(instr_op), m_op);
            chk("R1 R3 instr_arg", int'(instr_arg), m_arg);
            chk("R3 instr_len", int'(instr_len), m_len);
            chk("R3 instr_next_pc", int'(instr_next_pc), m_nxt);
            k = 0; ta = 0; t = "R7";
            if (m_op >= 'h300) begin
                k = 1; ta = (m_nxt & 14'h3F00) | (m_op & 'hFF); t = "R4";
            end else if (m_op >= 'h1C0 && m_op <= 'h1FF) begin
                k = 2; ta = m_op & 63; t = "R5";
            end else if (m_op >= 'h150 && m_op <= 'h17F) begin
                k = 3 + ((m_op - 'h150) >> 4);
                ta = ((m_op & 15) << 10) | m_arg; t = "R6";
            end
            chk({t, " tgt_kind"}, int'(tgt_kind), k);
            if (k != 0) chk({t, " tgt_addr"}, int'(tgt_addr), ta);
        end else begin
            chk("R7 idle tgt_kind", int'(tgt_kind), 0);
        end
    endtask

    // drive inputs for one cycle, then compare after the edge
    task automatic cyc(bit s, bit r, int ra);
        stall = s; redir_valid = r; redir_addr = 14'(ra);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) cyc(0, 0, 0);          // R10 reset state
        rst_n = 1'b1;
        cyc(1, 0, 0);

        // sweep every opcode value, spread over pages (R3..R7)
        ph = "sweep";
        for (int v = 0; v < 1024; v++) begin
            int p = v & 15;
            int a = (p << 10) | (v ^ page_mask(p << 10));
            cyc(0, 1, a);
            cyc(0, 0, 0);
            cyc(0, 0, 0);
        end

        // R4 R2: short branch at 0x3FFF, page wraps to 0
        ph = "R4 wrap";
        patch_en = 1; patch_a = 'h3FFF; patch_v = 'h3A5;
        cyc(0, 1, 'h3FFF); cyc(0, 0, 0); cyc(0, 0, 0);
        // R6 R2: long call at 0x3FFF, operand fetched from 0x0000
        patch_v = 'h165;
        cyc(0, 1, 'h3FFF); cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
        patch_en = 0;

        // R9: stall while operand is pending (opcode 0x105 at 0x105)
        ph = "R9 stall";
        cyc(0, 1, 'h105); cyc(0, 0, 0);
        repeat (3) cyc(1, 0, 0);
        cyc(0, 0, 0); cyc(0, 0, 0);

        // R8: redirect while operand is pending, then redirect plus stall
        ph = "R8 redirect";
        cyc(0, 1, 'h105); cyc(0, 0, 0);
        cyc(0, 1, 'h200); cyc(0, 0, 0); cyc(0, 0, 0);
        cyc(0, 1, 'h160); cyc(0, 0, 0);
        cyc(1, 1, 'h300); cyc(0, 0, 0); cyc(0, 0, 0);

        // mixed random stalls and redirects (R8 R9)
        ph = "mixed R8 R9";
        for (int i = 0; i < 4000; i++) begin
            bit s = ($urandom % 4) == 0;
            bit r = ($urandom % 8) == 0;
            cyc(s, r, int'($urandom % 16384));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule